// File: doc/BRIEF.md
# Switching Clock Generator with Half-Period Sync Link

This block derives the constant-frequency switching clock of a PWM power controller from a faster system clock. A period counter restarts every programmed number of system-clock cycles. Each restart is marked with a one-cycle `period_start` strobe, which the PWM and protection logic use to begin the power-switch on-time. A request of zero, or any value above the default, selects the default period (the free-running rate). Requests below one quarter of the default are raised to that quarter, so the rate can go at most four times above the free-running rate.

Two generators can be tied together through a sync line made of `sync_out`, `sync_oe` and `sync_in`. While it leads, the block drives the line and places a fixed-width pulse half a period after each of its own period starts. An incoming pulse is qualified first. It passes a two-flop synchronizer and must then stay high for a minimum number of cycles. If a qualified pulse arrives before the local counter reaches its terminal count, the block takes it as coming from a faster generator. It then becomes a follower: it restarts its period on every qualified pulse, releases the line and stops emitting pulses. Because the leader's pulse sits half a period into its cycle, the follower switches half a period after the leader. If a whole local period passes with no qualified pulse, the block leads again.

Top module: `swclk_gen`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `period_start`, `sync_out` and `slave_mode` are 0 and `sync_oe` is 1.
- R2: With `period_cfg` = 0 and no external pulses, `period_start` pulses exactly every DEF_PERIOD cycles.
- R3: The effective period P is DEF_PERIOD when `period_cfg` is 0 or above DEF_PERIOD. It is DEF_PERIOD/4 when `period_cfg` is below DEF_PERIOD/4, and `period_cfg` otherwise. Consecutive `period_start` pulses are P cycles apart.
- R4: While leading, `sync_out` goes high exactly floor(P/2) cycles after each `period_start` pulse and stays high for OUT_W cycles. `sync_out` is never high while `sync_oe` is low.
- R5: A high pulse on `sync_in` shorter than IN_MIN cycles has no effect: the period length and `slave_mode` are unchanged. A pulse of at least IN_MIN cycles that rises in cycle c produces `period_start` in cycle c+IN_MIN+2.
- R6: A qualified pulse that arrives while leading, before the terminal count, sets `slave_mode`, drives `sync_oe` and `sync_out` to 0, and restarts the period in the same cycle that `slave_mode` rises.
- R7: While following, every qualified pulse restarts the period with the fixed latency of R5, and `sync_oe` stays 0.
- R8: While following, if P cycles pass after a period start with no qualified pulse, the block restarts and clears `slave_mode` in the same cycle. It then emits its sync pulse again at floor(P/2).
- R9: A change of `period_cfg` takes effect at once. If the new P is at or below the current count plus one, `period_start` pulses in the cycle after the change.
- R10: A single long pulse on `sync_in` causes exactly one restart, however long it stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| period_cfg | input | CNT_W | Requested period in system-clock cycles; 0 selects the default |
| sync_in | input | 1 | Sync line as seen from the outside (asynchronous) |
| sync_out | output | 1 | Sync pulse level driven onto the line |
| sync_oe | output | 1 | High while the block leads and owns the line |
| period_start | output | 1 | One-cycle strobe at each switching period start |
| slave_mode | output | 1 | High while following an external generator |

## Verification
The bench builds the block with DEF_PERIOD = 40, OUT_W = 3 and IN_MIN = 4, which gives a minimum period of 10. These values make a whole period short enough to step through many of them. Each free-running cycle, fallback window and random period between 10 and 40 then takes only tens of cycles. A sync pulse can also be placed anywhere before the terminal count. The small IN_MIN lets the bench sit right at the qualification edge, with pulses of 3, 4 and 5 cycles, and a 20-cycle pulse shows that one pulse restarts the period only once.

// File: rtl/swclk_pkg.sv
package swclk_pkg;

    typedef enum logic {
        ROLE_LEAD   = 1'b0,
        ROLE_FOLLOW = 1'b1
    } role_e;

    typedef struct packed {
        logic accept;
        logic wrap;
    } tb_evt_t;

    function automatic logic [31:0] pick_period(input logic [31:0] req,
                                                input logic [31:0] def_p,
                                                input logic [31:0] min_p);
        if (req == 32'd0 || req > def_p) return def_p;
        else if (req < min_p)            return min_p;
        else                             return req;
    endfunction

    function automatic int bits_for(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/swclk_qual.sv
module swclk_qual import swclk_pkg::*; #(
    parameter int IN_MIN = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic accept
);
    localparam int RUN_W = bits_for(IN_MIN);

    logic             meta_q, sync_q;
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            run_q  <= '0;
        end else begin
            meta_q <= line_in;
            sync_q <= meta_q;
            if (!sync_q)
                run_q <= '0;
            else if (run_q != RUN_W'(IN_MIN))
                run_q <= run_q + 1'b1;
        end
    end

    // Fires once per pulse, in the IN_MIN-th synchronized high cycle
    assign accept = sync_q && (run_q == RUN_W'(IN_MIN - 1));
endmodule

// File: rtl/swclk_timebase.sv
module swclk_timebase import swclk_pkg::*; #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic             accept,
    output logic [CNT_W-1:0] cnt,
    output logic             start,
    output role_e            role
);
    tb_evt_t ev;

    always_comb begin
        ev.accept = accept;
        ev.wrap   = (cnt >= period - 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            start <= 1'b0;
            role  <= ROLE_LEAD;
        end else begin
            start <= ev.accept | ev.wrap;
            cnt   <= (ev.accept | ev.wrap) ? '0 : cnt + 1'b1;
            if (ev.accept && !ev.wrap)
                role <= ROLE_FOLLOW;
            else if (!ev.accept && ev.wrap)
                role <= ROLE_LEAD;
        end
    end
endmodule

// File: rtl/swclk_pulse.sv
module swclk_pulse import swclk_pkg::*; #(
    parameter int CNT_W = 16,
    parameter int OUT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half,
    input  role_e            role,
    output logic             line_out,
    output logic             line_oe
);
    localparam int PW_W = bits_for(OUT_W);

    logic [PW_W-1:0] pw_q;
    logic            fire;

    assign fire = (role == ROLE_LEAD) && (cnt == half - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || role == ROLE_FOLLOW)
            pw_q <= '0;
        else if (fire)
            pw_q <= PW_W'(OUT_W);
        else if (pw_q != '0)
            pw_q <= pw_q - 1'b1;
    end

    assign line_oe  = (role == ROLE_LEAD);
    assign line_out = (pw_q != '0) && (role == ROLE_LEAD);
endmodule

// File: rtl/swclk_gen.sv
module swclk_gen import swclk_pkg::*; #(
    parameter int CNT_W      = 16,
    parameter int DEF_PERIOD = 400,
    parameter int OUT_W      = 11,
    parameter int IN_MIN     = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_cfg,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             period_start,
    output logic             slave_mode
);
    localparam int MIN_PERIOD = DEF_PERIOD / 4;

    logic [CNT_W-1:0] eff_p, half_p, cnt;
    logic             accept;
    role_e            role;

    // R3: clamp the request; R9: recomputed every cycle
    assign eff_p  = CNT_W'(pick_period(32'(period_cfg), 32'(DEF_PERIOD), 32'(MIN_PERIOD)));
    assign half_p = eff_p >> 1;

    swclk_qual #(.IN_MIN(IN_MIN)) u_qual (
        .clk(clk), .rst(rst), .line_in(sync_in), .accept(accept)
    );

    swclk_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst(rst), .period(eff_p), .accept(accept),
        .cnt(cnt), .start(period_start), .role(role)
    );

    swclk_pulse #(.CNT_W(CNT_W), .OUT_W(OUT_W)) u_pulse (
        .clk(clk), .rst(rst), .cnt(cnt), .half(half_p), .role(role),
        .line_out(sync_out), .line_oe(sync_oe)
    );

    assign slave_mode = (role == ROLE_FOLLOW);
endmodule

// File: rtl/swclk_chk.sv
module swclk_chk #(
    parameter int DEF_PERIOD = 400,
    parameter int OUT_W      = 11
) (
    input logic clk,
    input logic rst,
    input logic period_start,
    input logic sync_out,
    input logic sync_oe,
    input logic slave_mode
);
    int gap_q;
    int hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= 0;
            hi_q  <= 0;
        end else begin
            gap_q <= period_start ? 1 : ((gap_q > DEF_PERIOD + 4) ? gap_q : gap_q + 1);
            hi_q  <= sync_out ? hi_q + 1 : 0;
        end
    end

    p_gap_bound_r2: assert property (@(posedge clk) disable iff (rst)
        !period_start |-> gap_q <= DEF_PERIOD);

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        ($fell(sync_out) && sync_oe && $past(sync_oe)) |-> hi_q == OUT_W);

    p_drive_owned_r4: assert property (@(posedge clk) disable iff (rst)
        sync_out |-> sync_oe);

    p_follow_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        slave_mode |-> (!sync_oe && !sync_out));

    p_entry_restart_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(slave_mode) |-> period_start);

    p_exit_restart_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(slave_mode) |-> period_start);
endmodule

bind swclk_gen swclk_chk #(.DEF_PERIOD(DEF_PERIOD), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .period_start(period_start), .sync_out(sync_out),
    .sync_oe(sync_oe), .slave_mode(slave_mode)
);

// File: tb/sim_swclk_gen.sv
module sim_swclk_gen;
    localparam int CW   = 16;
    localparam int DEFP = 40;
    localparam int OW   = 3;
    localparam int INM  = 4;
    localparam int MINP = DEFP / 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] period_cfg = '0;
    logic          sync_in = 1'b0;
    logic          sync_out, sync_oe, period_start, slave_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    swclk_gen #(.CNT_W(CW), .DEF_PERIOD(DEFP), .OUT_W(OW), .IN_MIN(INM)) u0 (
        .clk(clk), .rst(rst), .period_cfg(period_cfg), .sync_in(sync_in),
        .sync_out(sync_out), .sync_oe(sync_oe), .period_start(period_start),
        .slave_mode(slave_mode)
    );

    function automatic int exp_period(input int req);
        if (req == 0 || req > DEFP) return DEFP;
        if (req < MINP) return MINP;
        return req;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic align(output int n);
        n = -1;
        for (int k = 1; k <= 3 * DEFP; k++) begin
            @(negedge clk);
            if (period_start) begin n = k; break; end
        end
    endtask

    // Called at a negedge where period_start was seen; ends at the next one.
    task automatic run_period(input int inj_at, input int inj_w,
                              output int gap, output int rise, output int width,
                              output int oe_cnt);
        gap = -1; rise = -1; width = 0; oe_cnt = 0;
        for (int k = 1; k <= 3 * DEFP; k++) begin
            @(negedge clk);
            if (period_start) begin gap = k; break; end
            if (sync_out) begin
                if (rise < 0) rise = k;
                width++;
            end
            if (sync_oe) oe_cnt++;
            if (k == inj_at) sync_in = 1'b1;
            if (k == inj_at + inj_w) sync_in = 1'b0;
        end
    endtask

    initial begin
        int g, r, w, o, n, c, cfg, a, pw;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R1 period_start in reset", int'(period_start), 0);
        chk("R1 sync_out in reset", int'(sync_out), 0);
        chk("R1 sync_oe in reset", int'(sync_oe), 1);
        chk("R1 slave_mode in reset", int'(slave_mode), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 period_start after reset", int'(period_start), 0);

        // R2 / R4 free-running default
        align(n);
        for (int i = 0; i < 2; i++) begin
            run_period(-1, 0, g, r, w, o);
            chk("R2 default period", g, DEFP);
            chk("R4 sync rise offset", r, DEFP / 2);
            chk("R4 sync width", w, OW);
        end

        // R3 clamps
        period_cfg = CW'(DEFP + 17);
        align(n); align(n);
        run_period(-1, 0, g, r, w, o);
        chk("R3 above default", g, exp_period(DEFP + 17));
        period_cfg = CW'(3);
        align(n); align(n);
        run_period(-1, 0, g, r, w, o);
        chk("R3 below minimum", g, exp_period(3));
        chk("R4 rise at min period", r, exp_period(3) / 2);

        // R3 / R9 random programmed periods
        for (int i = 0; i < 6; i++) begin
            cfg = MINP + int'($urandom % (DEFP - MINP + 1));
            period_cfg = CW'(cfg);
            align(n); align(n);
            run_period(-1, 0, g, r, w, o);
            chk("R3 programmed period", g, exp_period(cfg));
            chk("R9 recomputed half point", r, exp_period(cfg) / 2);
        end

        // R9 shortening below current count
        period_cfg = '0;
        align(n); align(n);
        repeat (20) @(negedge clk);
        period_cfg = CW'(12);
        @(negedge clk);
        chk("R9 immediate restart", int'(period_start), 1);
        period_cfg = '0;
        align(n); align(n);

        // R5 short pulse ignored
        run_period(5, INM - 1, g, r, w, o);
        chk("R5 short pulse period", g, DEFP);
        chk("R5 short pulse mode", int'(slave_mode), 0);

        // R5 / R6 qualified pulse while leading
        run_period(5, INM, g, r, w, o);
        chk("R5 accept latency", g, 5 + INM + 2);
        chk("R6 slave_mode set", int'(slave_mode), 1);
        chk("R6 sync_oe released", int'(sync_oe), 0);

        // R7 following random pulses
        for (int i = 0; i < 5; i++) begin
            a  = 2 + int'($urandom % 20);
            pw = INM + int'($urandom % 2);
            run_period(a, pw, g, r, w, o);
            chk("R7 follow restart", g, a + INM + 2);
            chk("R7 still following", int'(slave_mode), 1);
            chk("R7 line not driven", o, 0);
        end

        // R10 long pulse gives one restart
        sync_in = 1'b1;
        c = 0;
        for (int k = 1; k <= 28; k++) begin
            @(negedge clk);
            if (period_start) c++;
            if (k == 20) sync_in = 1'b0;
        end
        chk("R10 single restart", c, 1);

        // R8 fallback after a silent period
        align(n);
        chk("R8 fallback timing", n, DEFP - (28 - (INM + 2)));
        chk("R8 slave_mode cleared", int'(slave_mode), 0);
        run_period(-1, 0, g, r, w, o);
        chk("R8 sync resumes rise", r, DEFP / 2);
        chk("R8 sync resumes width", w, OW);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule